// File: doc/BRIEF.md
# PCI Interrupt Router with Sticky Mapping Detection

This block takes the four interrupt pins (INTA..INTD) of every device slot on a PCI bus and merges them onto four active-high system interrupt lines. Two routings exist. The normal routing rotates each pin by its slot number plus a fixed offset that depends on the board variant. The legacy routing sends pin n straight to line n, whatever the slot.

Which routing applies is set by a small mode register. Reset loads it from an input. While it holds the undecided state, the block watches configuration writes to the interrupt-line byte of any function and classifies the value the software writes. The mode leaves the undecided state only once and then holds until the next reset. Forwarding the configuration write to the bus is done elsewhere. This block only observes the write strobe, address and data.

Top module: `pci_irq_router`

## Requirements
- R1: Mode encoding is 0 = undecided, 1 = legacy, 2 = correct. On a clock edge with `rst` high the mode loads `reset_mode`, with code 3 loading 0. `irq_out` clears to 0 during reset.
- R2: Once the mode is 1 or 2, no configuration write changes it until the next reset.
- R3: Classification happens only when all of these hold: `cfg_wr` is high, `variant_alt` is 0, the mode is 0, and `cfg_addr[7:0]` equals 0x3C. Any other write leaves the mode unchanged.
- R4: The slot of a write is the device number `cfg_addr[15:11]` taken modulo 4. The function bits `cfg_addr[10:8]` play no part.
- R5: Data 27 written in a slot with slot mod 4 equal to 2 keeps the mode at 0. Data 27 in any other slot sets the mode to 1.
- R6: Data equal to slot+27 or slot+91 (slot mod 4) sets the mode to 1. Any other data sets the mode to 2.
- R7: In mode 1, pin p of every slot drives `irq_out[p]`. Input `irq_lvl` bit s*4+p is pin p of slot s (p = 0 for INTA).
- R8: In modes 0 and 2, pin p of slot s drives `irq_out[(s+p+2) mod 4]` when `variant_alt` is 0, and `irq_out[(s+p+3) mod 4]` when it is 1.
- R9: Each output is the OR of every source routed to it, registered once. `irq_out` after edge k reflects `irq_lvl`, mode and `variant_alt` as sampled at edge k.
- R10: A classifying write sampled at edge k changes `mode` after edge k. `irq_out` produced at edge k still uses the old mode. The new mode applies from edge k+1 onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_mode | input | 2 | Mode loaded on reset (3 treated as 0) |
| variant_alt | input | 1 | 0 = basic board (offset 2, detection on), 1 = alternate board (offset 3, detection off) |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | ADDR_W (16) | Configuration address: device[15:11], function[10:8], register[7:0] |
| cfg_data | input | 8 | Byte written to the addressed register |
| irq_lvl | input | NUM_SLOTS*4 (32) | Interrupt pin levels, bit s*4+p = slot s pin p |
| irq_out | output | 4 | Registered system interrupt lines, active high |
| mode | output | 2 | Current routing mode |

## Verification
The bench builds the block with its defaults: eight slots, a 16-bit address and rotation offsets 2 and 3. Eight slots mean that slots 4 to 7 wrap around the modulo-4 rotation, and that device numbers 5 and 6 reach the detector as slots 1 and 2. This brings the slot reduction, both variant rotations and the slot-2 exception for the value 27 within reach of single writes. Each routing case drives one source at a time and then several at once. This exposes any rotation that is wrong by one, and any merge that is not an OR.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;

  typedef enum logic [1:0] {
    MODE_UNDECIDED = 2'd0,
    MODE_LEGACY    = 2'd1,
    MODE_CORRECT   = 2'd2
  } route_mode_t;

  localparam logic [7:0] LINE_REG_OFS = 8'h3C;
  localparam logic [7:0] LEGACY_BASE  = 8'd27;
  localparam logic [7:0] LATE_SHIFT   = 8'd64;

  // Decide what a written interrupt-line value says about the software.
  function automatic route_mode_t judge_line(input logic [1:0] slot,
                                             input logic [7:0] val);
    logic [7:0] slot8;
    slot8 = {6'b0, slot};
    if (val == LEGACY_BASE) begin
      judge_line = (slot == 2'd2) ? MODE_UNDECIDED : MODE_LEGACY;
    end else if (val == LEGACY_BASE + slot8 ||
                 val == LEGACY_BASE + LATE_SHIFT + slot8) begin
      judge_line = MODE_LEGACY;
    end else begin
      judge_line = MODE_CORRECT;
    end
  endfunction

endpackage

// File: rtl/irq_line_classifier.sv
module irq_line_classifier
  import pci_irq_router_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_data,
  input  logic              variant_alt,
  input  route_mode_t       cur_mode,
  output logic              upd_en,
  output route_mode_t       verdict
);
  localparam int DEV_LSB = 11;

  logic [1:0] slot_mod;
  logic       unused_addr_bits;

  assign slot_mod = cfg_addr[DEV_LSB+1:DEV_LSB];
  assign unused_addr_bits = ^{cfg_addr[ADDR_W-1:DEV_LSB+2], cfg_addr[DEV_LSB-1:8]};

  assign upd_en = cfg_wr && !variant_alt && (cur_mode == MODE_UNDECIDED) &&
                  (cfg_addr[7:0] == LINE_REG_OFS);
  assign verdict = judge_line(slot_mod, cfg_data);

endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg
  import pci_irq_router_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  reset_mode,
  input  logic        upd_en,
  input  route_mode_t verdict,
  output route_mode_t cur_mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      case (reset_mode)
        2'd1:    cur_mode <= MODE_LEGACY;
        2'd2:    cur_mode <= MODE_CORRECT;
        default: cur_mode <= MODE_UNDECIDED;
      endcase
    end else if (upd_en) begin
      cur_mode <= verdict;
    end
  end
endmodule

// File: rtl/irq_swizzle_router.sv
module irq_swizzle_router
  import pci_irq_router_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_OUT   = 4,
  parameter int ROT_BASIC = 2,
  parameter int ROT_ALT   = 3,
  localparam int NUM_SRC  = NUM_SLOTS * NUM_OUT,
  localparam int IDX_W    = $clog2(NUM_OUT)
) (
  input  logic               clk,
  input  logic               rst,
  input  route_mode_t        cur_mode,
  input  logic               variant_alt,
  input  logic [NUM_SRC-1:0] irq_lvl,
  output logic [NUM_OUT-1:0] irq_out
);
  logic [NUM_OUT-1:0] src_oh [NUM_SRC];
  logic [NUM_OUT-1:0] merged;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar p = 0; p < NUM_OUT; p++) begin : g_pin
      localparam int SRC = s * NUM_OUT + p;
      localparam logic [IDX_W-1:0] PASS_IDX = IDX_W'(p);
      localparam logic [IDX_W-1:0] BAS_IDX  = IDX_W'((s + p + ROT_BASIC) % NUM_OUT);
      localparam logic [IDX_W-1:0] ALT_IDX  = IDX_W'((s + p + ROT_ALT) % NUM_OUT);
      logic [IDX_W-1:0] dest;
      assign dest = (cur_mode == MODE_LEGACY) ? PASS_IDX :
                    (variant_alt ? ALT_IDX : BAS_IDX);
      assign src_oh[SRC] = irq_lvl[SRC] ? (NUM_OUT'(1) << dest) : '0;
    end
  end

  always_comb begin
    merged = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      merged = merged | src_oh[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= merged;
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_irq_router_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ADDR_W    = 16,
  parameter int ROT_BASIC = 2,
  parameter int ROT_ALT   = 3,
  localparam int NUM_PINS = 4,
  localparam int NUM_SRC  = NUM_SLOTS * NUM_PINS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         reset_mode,
  input  logic               variant_alt,
  input  logic               cfg_wr,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [7:0]         cfg_data,
  input  logic [NUM_SRC-1:0] irq_lvl,
  output logic [NUM_PINS-1:0] irq_out,
  output logic [1:0]         mode
);
  route_mode_t cur_mode;
  route_mode_t verdict;
  logic        upd_en;

  irq_line_classifier #(.ADDR_W(ADDR_W)) u_cls (
    .cfg_wr      (cfg_wr),
    .cfg_addr    (cfg_addr),
    .cfg_data    (cfg_data),
    .variant_alt (variant_alt),
    .cur_mode    (cur_mode),
    .upd_en      (upd_en),
    .verdict     (verdict)
  );

  irq_mode_reg u_mode (
    .clk        (clk),
    .rst        (rst),
    .reset_mode (reset_mode),
    .upd_en     (upd_en),
    .verdict    (verdict),
    .cur_mode   (cur_mode)
  );

  irq_swizzle_router #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_OUT   (NUM_PINS),
    .ROT_BASIC (ROT_BASIC),
    .ROT_ALT   (ROT_ALT)
  ) u_route (
    .clk         (clk),
    .rst         (rst),
    .cur_mode    (cur_mode),
    .variant_alt (variant_alt),
    .irq_lvl     (irq_lvl),
    .irq_out     (irq_out)
  );

  assign mode = cur_mode;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_SLOTS = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [1:0]             reset_mode,
  input logic                   variant_alt,
  input logic                   cfg_wr,
  input logic [NUM_SLOTS*4-1:0] irq_lvl,
  input logic [3:0]             irq_out,
  input logic [1:0]             mode
);
  logic [3:0] pin_or;
  always_comb begin
    pin_or = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      pin_or = pin_or | irq_lvl[s*4 +: 4];
    end
  end

  // R1
  a_r1_reset_load: assert property (@(posedge clk)
    rst |=> mode == (($past(reset_mode) == 2'd1) ? 2'd1 :
                     ($past(reset_mode) == 2'd2) ? 2'd2 : 2'd0));

  // R2
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd0) |=> $stable(mode));

  // R3
  a_r3_no_write_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(mode));

  // R3
  a_r3_alt_no_detect: assert property (@(posedge clk) disable iff (rst)
    (variant_alt && mode == 2'd0) |=> mode == 2'd0);

  // R1: mode code 3 is never held
  a_r1_legal_code: assert property (@(posedge clk) mode != 2'd3);

  // R7
  a_r7_legacy_route: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1) |=> irq_out == $past(pin_or));

  // R9
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    (irq_lvl == '0) |=> irq_out == 4'd0);
endmodule

bind pci_irq_router irq_router_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reset_mode  (reset_mode),
  .variant_alt (variant_alt),
  .cfg_wr      (cfg_wr),
  .irq_lvl     (irq_lvl),
  .irq_out     (irq_out),
  .mode        (mode)
);

// File: tb/sim_pci_irq_router.sv
module sim_pci_irq_router;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reset_mode = 2'd0;
  logic        variant_alt = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic [NS*4-1:0] irq_lvl = '0;
  logic [3:0]  irq_out;
  logic [1:0]  mode;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pci_irq_router #(.NUM_SLOTS(NS)) u0 (
    .clk(clk), .rst(rst), .reset_mode(reset_mode), .variant_alt(variant_alt),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .irq_lvl(irq_lvl), .irq_out(irq_out), .mode(mode)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_line(input int s, input int p, input int m, input bit alt);
    if (m == 1) return p;
    return (s % 4 + p + (alt ? 3 : 2)) % 4;
  endfunction

  task automatic do_reset(input logic [1:0] rm);
    rst = 1'b1; reset_mode = rm; cfg_wr = 1'b0; irq_lvl = '0; variant_alt = 1'b0;
    tick; tick;
    rst = 1'b0;
  endtask

  task automatic cfg_write(input int dev, input int fn, input logic [7:0] ofs,
                           input logic [7:0] data);
    cfg_addr = {5'(dev), 3'(fn), ofs};
    cfg_data = data;
    cfg_wr = 1'b1;
    tick;
    cfg_wr = 1'b0;
  endtask

  task automatic route_all(input bit alt, input int m, input string req);
    variant_alt = alt;
    for (int s = 0; s < NS; s++) begin
      for (int p = 0; p < 4; p++) begin
        irq_lvl = '0;
        irq_lvl[s*4+p] = 1'b1;
        tick;
        chk(req, int'(irq_out), 1 << exp_line(s, p, m, alt));
      end
    end
    irq_lvl = '0;
    tick;
  endtask

  task automatic t_reset;
    do_reset(2'd0); chk("R1 reset 0", int'(mode), 0); chk("R1 irq clear", int'(irq_out), 0);
    do_reset(2'd1); chk("R1 reset 1", int'(mode), 1);
    do_reset(2'd2); chk("R1 reset 2", int'(mode), 2);
    do_reset(2'd3); chk("R1 reset 3", int'(mode), 0);
  endtask

  task automatic t_routes;
    do_reset(2'd0);
    route_all(1'b0, 0, "R8 basic undecided");
    route_all(1'b1, 0, "R8 alt undecided");
    do_reset(2'd2);
    route_all(1'b0, 2, "R8 basic correct");
    do_reset(2'd1);
    route_all(1'b0, 1, "R7 legacy basic");
    route_all(1'b1, 1, "R7 legacy alt");
  endtask

  task automatic t_phase_one;
    do_reset(2'd0);
    cfg_write(3, 0, 8'h3C, 8'd27);
    chk("R5 27 in slot 3", int'(mode), 1);
    cfg_write(0, 0, 8'h3C, 8'd50);
    chk("R2 legacy sticky", int'(mode), 1);
    do_reset(2'd0);
    cfg_write(2, 0, 8'h3C, 8'd27);
    chk("R5 27 in slot 2", int'(mode), 0);
    cfg_write(6, 5, 8'h3C, 8'd27);
    chk("R4 dev 6 is slot 2", int'(mode), 0);
    cfg_write(5, 7, 8'h3C, 8'd28);
    chk("R4 R6 dev 5 value 28", int'(mode), 1);
  endtask

  task automatic t_phase_three;
    do_reset(2'd0);
    cfg_write(1, 0, 8'h3C, 8'd92);
    chk("R6 slot 1 value 92", int'(mode), 1);
    do_reset(2'd0);
    cfg_write(4, 0, 8'h3C, 8'd91);
    chk("R6 R4 dev 4 value 91", int'(mode), 1);
    do_reset(2'd0);
    cfg_write(3, 0, 8'h3C, 8'd30);
    chk("R6 slot 3 value 30", int'(mode), 1);
  endtask

  task automatic t_force;
    do_reset(2'd0);
    cfg_write(0, 0, 8'h3C, 8'd11);
    chk("R6 other value", int'(mode), 2);
    cfg_write(0, 0, 8'h3C, 8'd27);
    chk("R2 correct sticky", int'(mode), 2);
    do_reset(2'd0);
    cfg_write(1, 0, 8'h3C, 8'd91);
    chk("R6 slot 1 value 91", int'(mode), 2);
  endtask

  task automatic t_gating;
    do_reset(2'd0);
    cfg_write(0, 0, 8'h3D, 8'd27);
    chk("R3 wrong offset", int'(mode), 0);
    variant_alt = 1'b1;
    cfg_write(0, 0, 8'h3C, 8'd27);
    chk("R3 alt variant", int'(mode), 0);
    variant_alt = 1'b0;
    cfg_addr = 16'h003C; cfg_data = 8'd27; cfg_wr = 1'b0;
    tick;
    chk("R3 no strobe", int'(mode), 0);
    do_reset(2'd1);
    cfg_write(0, 0, 8'h3C, 8'd11);
    chk("R2 reset legacy sticky", int'(mode), 1);
  endtask

  task automatic t_merge;
    do_reset(2'd0);
    irq_lvl = '0;
    irq_lvl[0*4+0] = 1'b1;
    irq_lvl[1*4+3] = 1'b1;
    irq_lvl[5*4+1] = 1'b1;
    tick;
    chk("R9 merge basic", int'(irq_out), 4'b0101);
    irq_lvl = '1;
    tick;
    chk("R9 all high", int'(irq_out), 4'hF);
    irq_lvl = '0;
    tick;
    chk("R9 all low", int'(irq_out), 0);
  endtask

  task automatic t_switch_timing;
    do_reset(2'd0);
    irq_lvl = '0;
    irq_lvl[0] = 1'b1;
    cfg_write(0, 0, 8'h3C, 8'd27);
    chk("R10 old route on switch edge", int'(irq_out), 4'b0100);
    chk("R10 mode switched", int'(mode), 1);
    tick;
    chk("R10 new route next edge", int'(irq_out), 4'b0001);
    irq_lvl = '0;
    tick;
  endtask

  initial begin
    tick;
    t_reset;
    t_routes;
    t_phase_one;
    t_phase_three;
    t_force;
    t_gating;
    t_merge;
    t_switch_timing;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule